// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Service

This block is a bus-programmed interval timer. A 16-bit clock divider feeds a 16-bit period counter; both limits come from a single 32-bit count register. Once the run bit is set, the timer expires after divider × period clock cycles. In one-shot operation it then stops and clears its own run bit. In continuous operation it reloads and keeps running. Each timer expiry latches an event flag, and the flags can drive a level interrupt.

Setting the watchdog bit turns the block into a supervisor. An expiry then raises a sticky reset request instead of a timer event. Software keeps the system alive by writing a fixed key byte into the top byte of the mode register before the period runs out. From then until reset, the run and watchdog bits cannot be cleared.

Top module: `presc_wdt_timer`

## Requirements
- R1: After reset, the mode, count and status registers read 0, and irq and rst_req are low.
- R2: The register map is: address 0 mode (bit 8 interrupt enable, bit 10 continuous, bit 12 run, bit 15 watchdog; all other bits read 0), address 1 count (bits 31:16 divider, bits 15:0 period), address 2 status. Registers read back on bus_rdata in the same cycle the address is presented.
- R3: A write that sets the run bit from 0 starts the timer. Expiry happens at the clock edge D×P cycles after that write edge, where D is the divider value and P is the period value. A period value of 0 counts as 65536.
- R4: A divider value of 0 divides by 65536.
- R5: With continuous clear, an expiry sets status bit 0 and clears the run bit. No further expiry follows.
- R6: With continuous set, the timer reloads and expires every D×P cycles. An expiry while status bit 0 is already set also sets status bit 2 (overrun).
- R7: A write to the count register while running takes effect only at the next start or reload.
- R8: Clearing the run bit stops counting, and no later expiry occurs.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: irq is high exactly when interrupt enable is set and some status bit is set.
- R11: In watchdog mode, an expiry sets status bit 1 (not bit 0) and raises rst_req. rst_req stays high until reset.
- R12: In watchdog mode, a mode write whose bits 31:24 equal 0xA5 restarts the period and changes no mode bit. A mode write with any other top byte is an ordinary write and does not restart the period.
- R13: Once the watchdog bit is set, writes cannot clear it. While it and the run bit are both set, writes cannot clear the run bit. Only reset releases them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address (0 mode, 1 count, 2 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The hardest case to reach is proving that a key write really restarted the watchdog period, and that a look-alike write did not. From the ports the only evidence is when rst_req rises. The bench programs a 20-cycle watchdog and sends the key halfway through. It then sends a wrong-key write and an attempt to clear the lock. Finally it samples rst_req one cycle before and exactly at the key edge plus 20, and also at the unserviced expiry time. Long-divider behaviour is reached by running the full 65536-cycle divide and period windows and sampling on both sides of the expiry edge.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
   localparam int MODE_IRQ_BIT  = 8;
   localparam int MODE_CONT_BIT = 10;
   localparam int MODE_RUN_BIT  = 12;
   localparam int MODE_WDOG_BIT = 15;
   localparam int KEY_LSB       = 24;
   localparam int KEY_W         = 8;

   localparam logic [1:0] ADDR_MODE   = 2'd0;
   localparam logic [1:0] ADDR_COUNT  = 2'd1;
   localparam logic [1:0] ADDR_STATUS = 2'd2;

   localparam int ST_W   = 4;
   localparam int ST_TMO = 0;
   localparam int ST_WDG = 1;
   localparam int ST_OVR = 2;

   typedef struct packed {
      logic wdog;
      logic run;
      logic cont;
      logic irq_en;
   } mode_t;
endpackage

// File: rtl/ptw_divider.sv
`timescale 1ns/1ps
// Modulo counter with a limit latched on restart; used as both the
// clock divider and the period counter.
module ptw_divider #(
   parameter int W         = 16,
   parameter int ZERO_WRAP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         step,
   input  logic [W-1:0] load_val,
   output logic         wrap
);
   localparam int LW = W + 1;
   localparam logic [LW-1:0] FULL = {1'b1, {W{1'b0}}};
   localparam logic [LW-1:0] ONE  = {{W{1'b0}}, 1'b1};

   logic [LW-1:0] lim_new;
   logic [LW-1:0] lim_q;
   logic [W-1:0]  cnt_q;

   generate
      if (ZERO_WRAP != 0) begin : g_zero_full
         always_comb lim_new = (load_val == '0) ? FULL : {1'b0, load_val};
      end else begin : g_zero_one
         always_comb lim_new = (load_val == '0) ? ONE : {1'b0, load_val};
      end
   endgenerate

   assign wrap = step && ({1'b0, cnt_q} == (lim_q - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= FULL;
         cnt_q <= '0;
      end else if (restart) begin
         lim_q <= lim_new;
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ptw_ctrl.sv
`timescale 1ns/1ps
// Register file, lock rules, key service and event flags.
module ptw_ctrl
   import ptw_pkg::*;
#(
   parameter logic [KEY_W-1:0] KEY = 8'hA5,
   parameter int               DW  = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [1:0]      addr,
   input  logic [DW-1:0]   wdata,
   input  logic            per_wrap,
   output mode_t           mode_q,
   output logic [DW-1:0]   count_q,
   output logic [ST_W-1:0] status_q,
   output logic            restart,
   output logic            rst_req,
   output logic            irq
);
   logic mode_wr, count_wr, stat_wr, key_hit, svc, plain_wr, expire, start;
   mode_t mode_d;
   logic [ST_W-1:0] st_set, st_clr;

   assign mode_wr  = wr && (addr == ADDR_MODE);
   assign count_wr = wr && (addr == ADDR_COUNT);
   assign stat_wr  = wr && (addr == ADDR_STATUS);
   assign key_hit  = (wdata[KEY_LSB +: KEY_W] == KEY);
   assign svc      = mode_wr && key_hit && mode_q.wdog;
   assign plain_wr = mode_wr && !key_hit;
   assign expire   = per_wrap && !svc;

   always_comb begin
      mode_d = mode_q;
      if (expire && !mode_q.cont && !mode_q.wdog)
         mode_d.run = 1'b0;
      if (plain_wr) begin
         mode_d.irq_en = wdata[MODE_IRQ_BIT];
         mode_d.cont   = wdata[MODE_CONT_BIT];
         mode_d.run    = wdata[MODE_RUN_BIT] | (mode_q.wdog & mode_q.run);
         mode_d.wdog   = wdata[MODE_WDOG_BIT] | mode_q.wdog;
      end
   end

   assign start   = !mode_q.run && mode_d.run;
   assign restart = start || svc || (expire && (mode_q.cont || mode_q.wdog));

   always_comb begin
      st_set         = '0;
      st_set[ST_TMO] = expire && !mode_q.wdog;
      st_set[ST_WDG] = expire && mode_q.wdog;
      st_set[ST_OVR] = expire && !mode_q.wdog && status_q[ST_TMO];
      st_clr         = stat_wr ? wdata[ST_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         count_q  <= '0;
         status_q <= '0;
         rst_req  <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         status_q <= (status_q & ~st_clr) | st_set;
         if (count_wr)
            count_q <= wdata;
         if (st_set[ST_WDG])
            rst_req <= 1'b1;
      end
   end

   assign irq = mode_q.irq_en && (status_q != '0);
endmodule

// File: rtl/presc_wdt_timer.sv
`timescale 1ns/1ps
module presc_wdt_timer
   import ptw_pkg::*;
#(
   parameter int         PRE_W     = 16,
   parameter int         PER_W     = 16,
   parameter logic [7:0] KEY       = 8'hA5,
   parameter int         ZERO_WRAP = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        rst_req
);
   localparam int DW = PRE_W + PER_W;

   generate
      if (DW != 32) begin : g_bad_split
         $error("divider and period widths must fill the 32-bit count register");
      end
      if (PRE_W < 2 || PER_W < 2) begin : g_bad_width
         $error("divider and period need at least 2 bits each");
      end
   endgenerate

   mode_t           mode_q;
   logic [3:0]      mode_bits;
   logic [DW-1:0]   count_q;
   logic [ST_W-1:0] status_q;
   logic            restart, pre_tick, per_wrap;

   assign mode_bits = mode_q;

   ptw_ctrl #(.KEY(KEY), .DW(DW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .per_wrap(per_wrap),
      .mode_q  (mode_q),
      .count_q (count_q),
      .status_q(status_q),
      .restart (restart),
      .rst_req (rst_req),
      .irq     (irq)
   );

   ptw_divider #(.W(PRE_W), .ZERO_WRAP(ZERO_WRAP)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (mode_bits[2]),
      .load_val(count_q[DW-1:PER_W]),
      .wrap    (pre_tick)
   );

   ptw_divider #(.W(PER_W), .ZERO_WRAP(ZERO_WRAP)) u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (pre_tick),
      .load_val(count_q[PER_W-1:0]),
      .wrap    (per_wrap)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_MODE: begin
            bus_rdata[MODE_IRQ_BIT]  = mode_bits[0];
            bus_rdata[MODE_CONT_BIT] = mode_bits[1];
            bus_rdata[MODE_RUN_BIT]  = mode_bits[2];
            bus_rdata[MODE_WDOG_BIT] = mode_bits[3];
         end
         ADDR_COUNT:  bus_rdata = count_q;
         ADDR_STATUS: bus_rdata[ST_W-1:0] = status_q;
         default:     bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ptw_checker.sv
`timescale 1ns/1ps
module ptw_checker #(
   parameter logic [7:0] KEY = 8'hA5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic [1:0] bus_addr,
   input logic [7:0] key_byte,
   input logic       wdata_b0,
   input logic       rst_req,
   input logic [3:0] mode_bits,
   input logic       flag_tmo,
   input logic       per_wrap
);
   p_rst_req_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   p_rst_req_wdog_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> mode_bits[3]);

   p_wdog_lock_r13: assert property (@(posedge clk) disable iff (!rst_n)
      mode_bits[3] |=> mode_bits[3]);

   p_run_lock_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bits[3] && mode_bits[2]) |=> mode_bits[2]);

   p_key_keeps_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && key_byte == KEY && !per_wrap) |=> $stable(mode_bits));

   p_flag_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_tmo) |-> $past(bus_wr && bus_addr == 2'd2 && wdata_b0));

   p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (per_wrap && mode_bits[2] && !mode_bits[1] && !mode_bits[3] && !bus_wr) |=> !mode_bits[2]);
endmodule

bind presc_wdt_timer ptw_checker #(.KEY(KEY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .key_byte (bus_wdata[31:24]),
   .wdata_b0 (bus_wdata[0]),
   .rst_req  (rst_req),
   .mode_bits(mode_bits),
   .flag_tmo (status_q[0]),
   .per_wrap (per_wrap)
);

// File: tb/presc_wdt_timer_test.sv
`timescale 1ns/1ps
module presc_wdt_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq, rst_req;

   int cyc = 0;
   int last_edge = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   presc_wdt_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      bus_wr = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      last_edge = cyc;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd(2'd0, v); chk("R1 mode after reset", v, 32'h0);
      rd(2'd1, v); chk("R1 count after reset", v, 32'h0);
      rd(2'd2, v); chk("R1 status after reset", v, 32'h0);
      chk("R1 irq after reset", {31'd0, irq}, 32'h0);
      chk("R1 rst_req after reset", {31'd0, rst_req}, 32'h0);
   endtask

   task automatic t_oneshot();
      logic [31:0] v;
      int e;
      wr(2'd1, 32'h0003_0004);
      rd(2'd1, v); chk("R2 count readback", v, 32'h0003_0004);
      wr(2'd0, 32'h0000_1000); e = last_edge;
      rd(2'd0, v); chk("R2 run bit readback", v, 32'h0000_1000);
      wait_to(e + 11); rd(2'd2, v); chk("R3 no expiry before D*P", v, 32'h0);
      wait_to(e + 12); rd(2'd2, v); chk("R3 expiry at D*P", v, 32'h1);
      rd(2'd0, v); chk("R5 run cleared after one-shot", v, 32'h0);
      wait_to(e + 52); rd(2'd2, v); chk("R5 no second expiry", v, 32'h1);
      chk("R10 irq low with enable clear", {31'd0, irq}, 32'h0);
      wr(2'd2, 32'h1);
      rd(2'd2, v); chk("R9 write-one clears flag", v, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      int e;
      wr(2'd1, 32'h0002_0002);
      wr(2'd0, 32'h0000_1100); e = last_edge;
      wait_to(e + 3); #0.5; chk("R10 irq low before expiry", {31'd0, irq}, 32'h0);
      wait_to(e + 4); #0.5; chk("R10 irq high on flag", {31'd0, irq}, 32'h1);
      wr(2'd2, 32'h0000_000E);
      rd(2'd2, v); chk("R9 zero bits leave flag", v, 32'h1);
      chk("R10 irq still high", {31'd0, irq}, 32'h1);
      wr(2'd2, 32'h1);
      rd(2'd2, v); chk("R9 flag cleared", v, 32'h0);
      chk("R10 irq low after clear", {31'd0, irq}, 32'h0);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_continuous();
      logic [31:0] v;
      int e, s;
      wr(2'd1, 32'h0002_0005);
      wr(2'd0, 32'h0000_1400); e = last_edge;
      wait_to(e + 9);  rd(2'd2, v); chk("R6 before first expiry", v, 32'h0);
      wait_to(e + 10); rd(2'd2, v); chk("R6 first expiry", v, 32'h1);
      wait_to(e + 19); rd(2'd2, v); chk("R6 before second expiry", v, 32'h1);
      wait_to(e + 20); rd(2'd2, v); chk("R6 second expiry sets overrun", v, 32'h5);
      rd(2'd0, v); chk("R6 run stays set", v, 32'h0000_1400);
      wr(2'd0, 32'h0);
      wr(2'd2, 32'h7); s = last_edge;
      wait_to(s + 40); rd(2'd2, v); chk("R8 no expiry after stop", v, 32'h0);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      int e;
      wr(2'd1, 32'h0001_0008);
      wr(2'd0, 32'h0000_1400); e = last_edge;
      wait_to(e + 2);
      wr(2'd1, 32'h0001_0003);
      wait_to(e + 7);  rd(2'd2, v); chk("R7 old period still running", v, 32'h0);
      wait_to(e + 8);  rd(2'd2, v); chk("R7 expiry at old period", v, 32'h1);
      wr(2'd2, 32'h1);
      wait_to(e + 10); rd(2'd2, v); chk("R7 before new period ends", v, 32'h0);
      wait_to(e + 11); rd(2'd2, v); chk("R7 new period after reload", v, 32'h1);
      wr(2'd0, 32'h0);
      wr(2'd2, 32'h7);
   endtask

   task automatic t_zero_values();
      logic [31:0] v;
      int e;
      wr(2'd1, 32'h0000_0001);
      wr(2'd0, 32'h0000_1000); e = last_edge;
      wait_to(e + 65535); rd(2'd2, v); chk("R4 zero divider not early", v, 32'h0);
      wait_to(e + 65536); rd(2'd2, v); chk("R4 zero divider is 65536", v, 32'h1);
      wr(2'd2, 32'h7);
      wr(2'd1, 32'h0001_0000);
      wr(2'd0, 32'h0000_1000); e = last_edge;
      wait_to(e + 65535); rd(2'd2, v); chk("R3 zero period not early", v, 32'h0);
      wait_to(e + 65536); rd(2'd2, v); chk("R3 zero period is 65536", v, 32'h1);
      wr(2'd2, 32'h7);
   endtask

   task automatic t_watchdog();
      logic [31:0] v;
      int e, s;
      wr(2'd1, 32'h0001_0014);
      wr(2'd0, 32'h0000_9000); e = last_edge;
      wait_to(e + 9);
      wr(2'd0, 32'hA500_0000); s = last_edge;
      rd(2'd0, v); chk("R12 key leaves mode bits", v, 32'h0000_9000);
      wr(2'd0, 32'h5A00_9000);
      wr(2'd0, 32'h0000_0000);
      rd(2'd0, v); chk("R13 lock keeps run and watchdog", v, 32'h0000_9000);
      wait_to(e + 20); #0.5; chk("R12 key postponed expiry", {31'd0, rst_req}, 32'h0);
      wait_to(s + 19); #0.5; chk("R12 no request before restarted period", {31'd0, rst_req}, 32'h0);
      wait_to(s + 20); #0.5; chk("R11 request at restarted period", {31'd0, rst_req}, 32'h1);
      rd(2'd2, v); chk("R11 watchdog flag only", v, 32'h2);
      wait_to(s + 60); #0.5; chk("R11 request sticky", {31'd0, rst_req}, 32'h1);
      do_reset();
      chk("R11 request cleared by reset", {31'd0, rst_req}, 32'h0);
      rd(2'd0, v); chk("R13 reset releases lock", v, 32'h0);
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_oneshot();
      t_irq();
      t_continuous();
      t_reload();
      t_zero_values();
      t_watchdog();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog timeout actual=%0d expected=finished", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule